// File: doc/BRIEF.md
# CRC-16 T10-DIF Chunk Fold Engine

This block absorbs a byte message of at least 16 bytes, delivered as 16-byte words plus an optional ragged final word of 1 to 15 bytes. It keeps a 128-bit accumulator that stays congruent, modulo the T10-DIF generator, to the message with the seed applied. Each new full word is merged by multiplying the two 64-bit halves of the accumulator by precomputed residues of x^128 and x^192. The block never steps the CRC one bit at a time.

A transfer opens with a one-cycle `start_i` that captures the 16-bit seed. Data words then arrive on a valid/ready handshake. The word carrying `last_i` closes the message. Its `bytes_i` field gives the tail length, or 0 when that word is full. A short tail is handled by shifting the accumulator left by the tail length and placing the tail bytes at its low end. The bytes pushed out at the top are then folded back in with the same constants. When the message is finished, `rem_o` holds the 128-bit remainder and `done_o` pulses once. A downstream stage reduces `rem_o` to the final 16-bit CRC.

Top module: `crc_t10_fold`

## Requirements
- R1: Bits `data_i[127:120]` carry the earliest byte of a word. Bit 7 of each byte is its highest-order coefficient. Reducing `rem_o`·x^16 modulo G(x) = 0x18BB7 gives the MSB-first CRC-16 of the message, computed with the seed as initial value, no reflection and no output inversion.
- R2: The seed is XORed only into bits [127:112] of the first word. All other accumulator bits of the first word equal the data bits.
- R3: For a 16-byte message (first word has `last_i`=1 and `bytes_i`=0), `rem_o` equals `data_i` XOR {seed, 112'b0} exactly.
- R4: For each further full word D, the new accumulator is D ^ clmul(acc[63:0], 0xA010) ^ clmul(acc[127:64], 0x1FAA).
- R5: On a final word with `bytes_i`=n (1..15), only `data_i[127:128-8n]` is used. The other bytes have no effect on `rem_o`.
- R6: `ready_o` is low in the cycle after a word is accepted past the first one. At most one word is absorbed per fold.
- R7: `done_o` is high for exactly one cycle per message. `rem_o` holds its value after that cycle until the next message writes it.
- R8: After reset, `ready_o` and `done_o` are 0 and `rem_o` is all zeros. `ready_o` stays 0 until `start_i` is seen.
- R9: `start_i` is ignored while a message is in progress. The seed captured at the opening pulse stays in use for the rest of that message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Opens a message and captures `init_i`; only acted on when idle |
| init_i | input | 16 | CRC seed |
| valid_i | input | 1 | Data word valid |
| ready_o | output | 1 | Engine can take a word |
| data_i | input | 128 | Data word, earliest byte in bits [127:120] |
| last_i | input | 1 | Word closes the message |
| bytes_i | input | 4 | Tail byte count on the last word; 0 means a full word |
| rem_o | output | 128 | Folded 128-bit remainder |
| done_o | output | 1 | One-cycle pulse when `rem_o` is final |

## Verification
The assertions assume that the first word of a message is always full. A first word carrying `last_i` with a nonzero `bytes_i` would make a message shorter than 16 bytes. The assertions also assume that `bytes_i` is only meaningful together with `last_i`.

The stimulus respects these assumptions. Every message it sends is 16 bytes or longer. It computes `bytes_i` from the message length and drives it only on the closing word. Inputs are held steady until the design takes the word. Bytes beyond the tail are filled on purpose with varying values, so that their lack of effect is observed at `rem_o`.

// File: rtl/crc_fold_pkg.sv
package crc_fold_pkg;
  localparam int CHUNK_W = 128;
  localparam int HALF_W  = CHUNK_W / 2;
  localparam int CRC_W   = 16;
  localparam int BYTE_W  = 8;
  localparam int NBYTES  = CHUNK_W / BYTE_W;
  localparam int CNT_W   = $clog2(NBYTES);
  localparam int SH_W    = $clog2(CHUNK_W) + 1;
  localparam int PROD_W  = HALF_W + CRC_W - 1;

  // residues of x^128 and x^192 modulo 0x18BB7
  localparam logic [CRC_W-1:0] K_LO = 16'hA010;
  localparam logic [CRC_W-1:0] K_HI = 16'h1FAA;

  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_NEXT, ST_FOLD} fold_state_e;
endpackage

// File: rtl/crc_clmul.sv
module crc_clmul #(
  parameter int A_W = 64,
  parameter int B_W = 16,
  localparam int P_W = A_W + B_W - 1
) (
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic [P_W-1:0] p_o
);
  logic [P_W-1:0] part [B_W+1];
  assign part[0] = '0;

  for (genvar i = 0; i < B_W; i++) begin : g_term
    assign part[i+1] = part[i] ^ (b_i[i] ? ({{(B_W-1){1'b0}}, a_i} << i) : '0);
  end

  assign p_o = part[B_W];
endmodule

// File: rtl/crc_fold_step.sv
module crc_fold_step
  import crc_fold_pkg::*;
(
  input  logic [CHUNK_W-1:0] src_i,
  input  logic [CHUNK_W-1:0] mix_i,
  output logic [CHUNK_W-1:0] res_o
);
  logic [PROD_W-1:0] p_lo, p_hi;

  crc_clmul #(.A_W(HALF_W), .B_W(CRC_W)) u_lo (
    .a_i(src_i[HALF_W-1:0]), .b_i(K_LO), .p_o(p_lo)
  );
  crc_clmul #(.A_W(HALF_W), .B_W(CRC_W)) u_hi (
    .a_i(src_i[CHUNK_W-1:HALF_W]), .b_i(K_HI), .p_o(p_hi)
  );

  assign res_o = mix_i
               ^ {{(CHUNK_W-PROD_W){1'b0}}, p_lo}
               ^ {{(CHUNK_W-PROD_W){1'b0}}, p_hi};
endmodule

// File: rtl/crc_tail_align.sv
module crc_tail_align
  import crc_fold_pkg::*;
(
  input  logic [CHUNK_W-1:0] acc_i,
  input  logic [CHUNK_W-1:0] data_i,
  input  logic [CNT_W-1:0]   nbytes_i,
  output logic [CHUNK_W-1:0] chunk_o,
  output logic [CHUNK_W-1:0] spill_o
);
  logic [SH_W-1:0] sh_in, sh_out;

  assign sh_in  = {{(SH_W-CNT_W-3){1'b0}}, nbytes_i, 3'b000};
  assign sh_out = SH_W'(CHUNK_W) - sh_in;

  // tail bytes sit at the top of data_i; move them to the low end
  assign chunk_o = (acc_i << sh_in) | (data_i >> sh_out);
  assign spill_o = acc_i >> sh_out;
endmodule

// File: rtl/crc_t10_fold.sv
module crc_t10_fold
  import crc_fold_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [CRC_W-1:0]   init_i,
  input  logic               valid_i,
  output logic               ready_o,
  input  logic [CHUNK_W-1:0] data_i,
  input  logic               last_i,
  input  logic [CNT_W-1:0]   bytes_i,
  output logic [CHUNK_W-1:0] rem_o,
  output logic               done_o
);
  fold_state_e        state_q;
  logic [CHUNK_W-1:0] acc_q, chunk_q;
  logic [CRC_W-1:0]   init_q;
  logic [CNT_W-1:0]   nb_q;
  logic               last_q, tail_q, done_q;
  logic [CHUNK_W-1:0] al_chunk, al_spill, fold_src, fold_mix, fold_res;
  logic               accept;

  assign ready_o = (state_q == ST_FIRST) || (state_q == ST_NEXT);
  assign accept  = valid_i && ready_o;

  crc_tail_align u_align (
    .acc_i(acc_q), .data_i(chunk_q), .nbytes_i(nb_q),
    .chunk_o(al_chunk), .spill_o(al_spill)
  );

  // shared fold: spilled bytes on a ragged tail, whole accumulator otherwise
  assign fold_src = tail_q ? al_spill : acc_q;
  assign fold_mix = tail_q ? al_chunk : chunk_q;

  crc_fold_step u_fold (.src_i(fold_src), .mix_i(fold_mix), .res_o(fold_res));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      acc_q   <= '0;
      chunk_q <= '0;
      init_q  <= '0;
      nb_q    <= '0;
      last_q  <= 1'b0;
      tail_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          init_q  <= init_i;
          state_q <= ST_FIRST;
        end
        ST_FIRST: if (valid_i) begin
          acc_q <= data_i ^ {init_q, {(CHUNK_W-CRC_W){1'b0}}};
          if (last_i) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_NEXT;
          end
        end
        ST_NEXT: if (valid_i) begin
          chunk_q <= data_i;
          last_q  <= last_i;
          nb_q    <= last_i ? bytes_i : '0;
          tail_q  <= last_i && (bytes_i != '0);
          state_q <= ST_FOLD;
        end
        ST_FOLD: begin
          acc_q <= fold_res;
          if (last_q) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_NEXT;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rem_o  = acc_q;
  assign done_o = done_q;

  AST_FOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && state_q == ST_NEXT) |=> !ready_o); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_REM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> $stable(rem_o)); // R7
  AST_FIRST_BODY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && state_q == ST_FIRST) |=> rem_o[CHUNK_W-CRC_W-1:0] == $past(data_i[CHUNK_W-CRC_W-1:0])); // R2
  AST_FIRST_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && state_q == ST_FIRST && last_i) |-> bytes_i == '0); // R3
endmodule

// File: tb/tb_crc_t10_fold.sv
module tb_crc_t10_fold;
  logic         clk = 1'b0, rst_n = 1'b0;
  logic         start = 1'b0, valid = 1'b0, last = 1'b0;
  logic [15:0]  init = '0;
  logic [127:0] data = '0;
  logic [3:0]   nb = '0;
  logic         ready, done;
  logic [127:0] rem;
  int           n_run = 0, n_fail = 0;
  logic [7:0]   msg [256];

  always #4 clk = ~clk;

  crc_t10_fold dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .init_i(init),
    .valid_i(valid), .ready_o(ready), .data_i(data), .last_i(last),
    .bytes_i(nb), .rem_o(rem), .done_o(done)
  );

  // init[31:16] len[15:8] seed[7:0]
  localparam int NV = 10;
  localparam logic [31:0] VEC [NV] = '{
    {16'h0000, 8'd16,  8'h01}, {16'h1D0F, 8'd16,  8'h22},
    {16'h0000, 8'd17,  8'h03}, {16'hABCD, 8'd31,  8'h44},
    {16'hFFFF, 8'd32,  8'h05}, {16'h0000, 8'd33,  8'h66},
    {16'h5A5A, 8'd47,  8'h07}, {16'h0123, 8'd48,  8'h08},
    {16'h8001, 8'd100, 8'h09}, {16'hFFFF, 8'd255, 8'h0A}
  };

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_byte(logic [15:0] c, logic [7:0] b);
    c = c ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ 16'h8BB7) : (c << 1);
    return c;
  endfunction

  function automatic logic [15:0] crc_ref(logic [15:0] seed, int len);
    logic [15:0] c = seed;
    for (int i = 0; i < len; i++) c = crc_byte(c, msg[i]);
    return c;
  endfunction

  function automatic logic [15:0] reduce(logic [127:0] r);
    logic [15:0] c = '0;
    for (int i = 0; i < 16; i++) c = crc_byte(c, r[127-8*i -: 8]);
    return c;
  endfunction

  function automatic logic [127:0] clmul(logic [63:0] a, logic [15:0] b);
    logic [127:0] p = '0;
    for (int i = 0; i < 16; i++) if (b[i]) p = p ^ ({64'd0, a} << i);
    return p;
  endfunction

  function automatic void fill(logic [7:0] seed, int len);
    for (int i = 0; i < 256; i++) msg[i] = (i < len) ? 8'((int'(seed) * 37 + i * 13 + (i >> 2)) & 255) : 8'h00;
  endfunction

  function automatic logic [127:0] word_of(int c, int len, logic [7:0] gfill);
    logic [127:0] w;
    for (int b = 0; b < 16; b++) w[127-8*b -: 8] = (c * 16 + b < len) ? msg[c * 16 + b] : gfill;
    return w;
  endfunction

  task automatic run_msg(input logic [15:0] seed, input int len, input logic [7:0] gfill,
                         input bit mid_start, output logic [127:0] res);
    int total = (len + 15) / 16;
    @(negedge clk); start = 1'b1; init = seed;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < total; c++) begin
      data  = word_of(c, len, gfill);
      last  = (c == total - 1);
      nb    = last ? 4'(len % 16) : 4'd0;
      valid = 1'b1;
      while (!ready) @(negedge clk);
      @(negedge clk);
      valid = 1'b0;
      if (c == 1) chk(ready == 1'b0, "R6 ready low in fold cycle", {127'd0, ready}, 128'd0);
      if (mid_start && c == 1) begin
        start = 1'b1; init = ~seed;
        @(negedge clk);
        start = 1'b0;
      end
    end
    while (!done) @(negedge clk);
    res = rem;
    @(negedge clk);
    chk(done == 1'b0, "R7 done lasts one cycle", {127'd0, done}, 128'd0);
    chk(rem == res, "R7 rem held after done", rem, res);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [127:0] r, r2, a;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(ready == 1'b0, "R8 ready after reset", {127'd0, ready}, 128'd0);
    chk(done == 1'b0, "R8 done after reset", {127'd0, done}, 128'd0);
    chk(rem == '0, "R8 rem after reset", rem, 128'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ready == 1'b0, "R8 ready idle before start", {127'd0, ready}, 128'd0);

    // R1 table walk
    for (int v = 0; v < NV; v++) begin
      fill(VEC[v][7:0], int'(VEC[v][15:8]));
      run_msg(VEC[v][31:16], int'(VEC[v][15:8]), 8'h00, 1'b0, r);
      chk(reduce(r) == crc_ref(VEC[v][31:16], int'(VEC[v][15:8])), "R1 remainder congruent to CRC",
          {112'd0, reduce(r)}, {112'd0, crc_ref(VEC[v][31:16], int'(VEC[v][15:8]))});
    end

    // R3 exact 16-byte result
    fill(8'h33, 16);
    run_msg(16'hBEEF, 16, 8'h00, 1'b0, r);
    chk(r == (word_of(0, 16, 8'h00) ^ {16'hBEEF, 112'd0}), "R3 single word exact", r,
        word_of(0, 16, 8'h00) ^ {16'hBEEF, 112'd0});

    // R2 seed lands on top 16 bits only
    run_msg(16'h0000, 16, 8'h00, 1'b0, r2);
    chk((r ^ r2) == {16'hBEEF, 112'd0}, "R2 seed only in top bits", r ^ r2, {16'hBEEF, 112'd0});

    // R4 exact two-word fold
    fill(8'h5C, 32);
    run_msg(16'h7777, 32, 8'h00, 1'b0, r);
    a = word_of(0, 32, 8'h00) ^ {16'h7777, 112'd0};
    chk(r == (word_of(1, 32, 8'h00) ^ clmul(a[63:0], 16'hA010) ^ clmul(a[127:64], 16'h1FAA)),
        "R4 fold formula", r, word_of(1, 32, 8'h00) ^ clmul(a[63:0], 16'hA010) ^ clmul(a[127:64], 16'h1FAA));

    // R5 bytes past the tail are ignored
    fill(8'h91, 37);
    run_msg(16'h4321, 37, 8'h00, 1'b0, r);
    run_msg(16'h4321, 37, 8'hA5, 1'b0, r2);
    chk(r == r2, "R5 tail filler ignored", r2, r);
    chk(reduce(r2) == crc_ref(16'h4321, 37), "R5 tail CRC", {112'd0, reduce(r2)}, {112'd0, crc_ref(16'h4321, 37)});
    fill(8'h12, 47);
    run_msg(16'h0F0F, 47, 8'hFF, 1'b0, r);
    chk(reduce(r) == crc_ref(16'h0F0F, 47), "R5 15-byte tail CRC", {112'd0, reduce(r)}, {112'd0, crc_ref(16'h0F0F, 47)});

    // R9 start mid-message ignored
    fill(8'hE4, 64);
    run_msg(16'h2468, 64, 8'h00, 1'b1, r);
    chk(reduce(r) == crc_ref(16'h2468, 64), "R9 start ignored while busy", {112'd0, reduce(r)}, {112'd0, crc_ref(16'h2468, 64)});

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule